// File: doc/BRIEF.md
# Processor Run and Clock Control

This block decides whether the processor core is running and which oscillator paces its phase-2 clock. Two instruction strobes put the core to sleep. The wait strobe gives a light sleep that an enabled interrupt or a reset ends. The stop strobe gives a deep sleep that only a reset ends. While the core sleeps, phase-2 runs on until it reaches its high level and then stays there.

A two-bit speed register is written by the core. One bit turns the fast oscillator on. The other asks for the fast oscillator as the phase-2 source. The slow and fast clocks reach the block as single-cycle tick enables on one reference clock. Phase-2 is a level that toggles on each tick of the selected source.

A single status pin reports the run state. In debug mode the pin is shared by clock phase: it shows the opcode-fetch flag while phase-2 is low and the run state while phase-2 is high.

Top module: `cpu_run_clkctl`

## Requirements
- R1: While reset is low, and right after it, `sc_q_o` is 00, `run_o` and `status_o` are 1, `clk_sel_o`, `fast_osc_o` and `phi2_o` are 0.
- R2: A `wai_i` pulse without `irq_i` drives `run_o` low on the next cycle, and it stays low with no further input.
- R3: After a wait halt, an `irq_i` pulse returns `run_o` to 1 on the next cycle.
- R4: When `wai_i` and `irq_i` are high in the same cycle, `run_o` stays 1.
- R5: A `stp_i` pulse drives `run_o` low on the next cycle, and `irq_i` does not release it.
- R6: Reset low releases both the wait halt and the stop halt, and it clears the speed register.
- R7: While `run_o` is 0, `phi2_o` keeps toggling until it reaches 1 (the HALT_LEVEL default) and then holds that level.
- R8: With `emu_i`=0, `status_o` equals `run_o`. With `emu_i`=1, `status_o` equals `sync_i` while `phi2_o` is 0 and equals `run_o` while `phi2_o` is 1.
- R9: `be_i` has no effect on `run_o` or `status_o`.
- R10: A cycle with `sc_we_i` high loads `sc_wdata_i` into `sc_q_o`. Bit 0 set drives `fast_osc_o` high. `fast_osc_o` also stays high while the fast source is still in use.
- R11: `clk_sel_o` becomes 1 only when both speed bits are 1. It changes only at the end of a phase-2 cycle, that is, on the tick where `phi2_o` goes from 1 to 0.
- R12: While running, `phi2_o` toggles once per tick of the selected source: once per `slow_tick_i` when `clk_sel_o`=0, and once per `fast_tick_i` when `clk_sel_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | Slow clock tick enable |
| fast_tick_i | input | 1 | Fast clock tick enable |
| wai_i | input | 1 | Wait instruction strobe |
| stp_i | input | 1 | Stop instruction strobe |
| irq_i | input | 1 | Enabled interrupt request |
| sync_i | input | 1 | Opcode fetch flag |
| emu_i | input | 1 | Debug mode: share the status pin by phase |
| be_i | input | 1 | Bus enable (ignored) |
| sc_we_i | input | 1 | Speed register write strobe |
| sc_wdata_i | input | 2 | Speed register write data |
| sc_q_o | output | 2 | Speed register contents |
| fast_osc_o | output | 1 | Fast oscillator enable |
| clk_sel_o | output | 1 | Active phase-2 source (1 = fast) |
| phi2_o | output | 1 | Phase-2 clock level |
| run_o | output | 1 | Core is running |
| status_o | output | 1 | Shared run and sync status pin |

## Verification
The bench builds the block with HALT_LEVEL at its default of 1, so phase-2 stops in the high state. It generates a slow tick every eight reference cycles and a fast tick every two. This makes toggle counts over a 64-cycle window exact: 8 on the slow source and 32 on the fast one. It also lets a source switch be caught at its boundary edge. Because one run reaches both halt kinds, the phase-shared status pin and a source change, the bench can test the interrupt priority, stop stickiness and release by reset against the same frozen clock level.

// File: rtl/cpu_run_clkctl.sv
module cpu_run_clkctl #(
  parameter logic HALT_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick_i,
  input  logic       fast_tick_i,
  input  logic       wai_i,
  input  logic       stp_i,
  input  logic       irq_i,
  input  logic       sync_i,
  input  logic       emu_i,
  input  logic       be_i,
  input  logic       sc_we_i,
  input  logic [1:0] sc_wdata_i,
  output logic [1:0] sc_q_o,
  output logic       fast_osc_o,
  output logic       clk_sel_o,
  output logic       phi2_o,
  output logic       run_o,
  output logic       status_o
);

  logic [1:0] sc_q;
  logic       wai_q, stp_q, src_q, phi2_q;
  logic       halted, tick, frozen, fast_req;

  assign halted   = wai_q | stp_q;
  assign tick     = src_q ? fast_tick_i : slow_tick_i;
  assign frozen   = halted && (phi2_q == HALT_LEVEL);
  assign fast_req = sc_q[1] & sc_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else if (sc_we_i) sc_q <= sc_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wai_q <= 1'b0;
      stp_q <= 1'b0;
    end else begin
      if (irq_i) wai_q <= 1'b0;
      else if (wai_i) wai_q <= 1'b1;
      if (stp_i) stp_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi2_q <= 1'b0;
      src_q  <= 1'b0;
    end else if (tick && !frozen) begin
      phi2_q <= ~phi2_q;
      if (phi2_q) src_q <= fast_req;
    end
  end

  assign sc_q_o     = sc_q;
  assign fast_osc_o = sc_q[0] | src_q;
  assign clk_sel_o  = src_q;
  assign phi2_o     = phi2_q;
  assign run_o      = ~halted;
  assign status_o   = (emu_i && !phi2_q) ? sync_i : ~halted;

endmodule

// File: rtl/cpu_run_clkctl_chk.sv
module cpu_run_clkctl_chk #(
  parameter logic HALT_LEVEL = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wai_i,
  input logic       stp_i,
  input logic       irq_i,
  input logic       be_i,
  input logic       clk_sel_o,
  input logic       phi2_o,
  input logic       run_o
);

  logic stp_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stp_seen <= 1'b0;
    else if (stp_i) stp_seen <= 1'b1;
  end

  AST_WAI_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (wai_i && !irq_i) |=> !run_o); // R2

  AST_IRQ_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (wai_i && irq_i && run_o && !stp_i) |=> run_o); // R4

  AST_STP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stp_seen |-> !run_o); // R5

  AST_PHI2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && phi2_o == HALT_LEVEL) |=> (phi2_o == HALT_LEVEL)); // R7

  AST_SRC_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_o != $past(clk_sel_o)) |-> ($past(phi2_o) && !phi2_o)); // R11

  AST_BE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (be_i || !be_i) |-> !$isunknown(run_o)); // R9

endmodule

bind cpu_run_clkctl cpu_run_clkctl_chk #(.HALT_LEVEL(HALT_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wai_i(wai_i), .stp_i(stp_i), .irq_i(irq_i),
  .be_i(be_i), .clk_sel_o(clk_sel_o), .phi2_o(phi2_o), .run_o(run_o)
);

// File: tb/sim_cpu_run_clkctl.sv
`timescale 1ns/1ps
module sim_cpu_run_clkctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0, fast_tick = 1'b0;
  logic wai = 1'b0, stp = 1'b0, irq = 1'b0, sync = 1'b0, emu = 1'b0, be = 1'b0;
  logic sc_we = 1'b0;
  logic [1:0] sc_wdata = 2'b00;
  logic [1:0] sc_q;
  logic fast_osc, clk_sel, phi2, run, status;
  int checks = 0, fails = 0;
  int tcnt = 0;

  always #4 clk = ~clk;

  cpu_run_clkctl u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick_i(slow_tick), .fast_tick_i(fast_tick),
    .wai_i(wai), .stp_i(stp), .irq_i(irq), .sync_i(sync), .emu_i(emu), .be_i(be),
    .sc_we_i(sc_we), .sc_wdata_i(sc_wdata), .sc_q_o(sc_q), .fast_osc_o(fast_osc),
    .clk_sel_o(clk_sel), .phi2_o(phi2), .run_o(run), .status_o(status)
  );

  initial forever begin
    @(negedge clk);
    tcnt++;
    slow_tick = (tcnt % 8 == 0);
    fast_tick = (tcnt % 2 == 0);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_toggles(input int n, output int cnt);
    logic prev;
    cnt = 0;
    @(negedge clk);
    prev = phi2;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (phi2 !== prev) cnt++;
      prev = phi2;
    end
  endtask

  task automatic pulse_wai_irq(input logic w, input logic s, input logic q);
    @(negedge clk);
    wai = w; stp = s; irq = q;
    @(negedge clk);
    wai = 1'b0; stp = 1'b0; irq = 1'b0;
  endtask

  task automatic sc_write(input logic [1:0] v);
    @(negedge clk);
    sc_we = 1'b1; sc_wdata = v;
    @(negedge clk);
    sc_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6 run in reset", run, 1);
    chk("R6 sc in reset", sc_q, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    wait_cyc(2);
    chk("R1 sc_q", sc_q, 0);
    chk("R1 run", run, 1);
    chk("R1 status", status, 1);
    chk("R1 clk_sel", clk_sel, 0);
    chk("R1 fast_osc", fast_osc, 0);
    chk("R1 phi2", phi2, 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 run after release", run, 1);
  endtask

  task automatic t_slow();
    int c;
    count_toggles(64, c);
    chk("R12 slow toggles", c, 8);
  endtask

  task automatic t_sel_without_osc();
    sc_write(2'b10);
    chk("R10 sc readback", sc_q, 2);
    wait_cyc(40);
    chk("R11 no fast without osc", clk_sel, 0);
    chk("R10 osc off", fast_osc, 0);
  endtask

  task automatic t_fast();
    int c;
    logic prev_phi, prev_sel;
    logic seen;
    seen = 1'b0;
    sc_write(2'b11);
    chk("R10 osc on", fast_osc, 1);
    prev_phi = phi2; prev_sel = clk_sel;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clk_sel !== prev_sel) begin
        seen = 1'b1;
        chk("R11 switch at boundary phi2 now", phi2, 0);
        chk("R11 switch at boundary phi2 before", prev_phi, 1);
      end
      prev_phi = phi2; prev_sel = clk_sel;
    end
    chk("R11 fast selected", clk_sel, 1);
    chk("R11 switch observed", seen, 1);
    count_toggles(64, c);
    chk("R12 fast toggles", c, 32);
    sc_write(2'b00);
    chk("R10 osc held while fast in use", fast_osc, clk_sel);
    wait_cyc(20);
    chk("R11 back to slow", clk_sel, 0);
    chk("R10 osc off after switch", fast_osc, 0);
  endtask

  task automatic t_wai();
    int c;
    pulse_wai_irq(1, 0, 0);
    chk("R2 run low after wai", run, 0);
    wait_cyc(40);
    chk("R2 run still low", run, 0);
    chk("R7 phi2 held high", phi2, 1);
    count_toggles(32, c);
    chk("R7 no toggles while halted", c, 0);
    pulse_wai_irq(0, 0, 1);
    chk("R3 irq wakes", run, 1);
  endtask

  task automatic t_wai_irq_same();
    pulse_wai_irq(1, 0, 1);
    chk("R4 irq wins", run, 1);
    wait_cyc(4);
    chk("R4 still running", run, 1);
  endtask

  task automatic t_wai_reset();
    pulse_wai_irq(1, 0, 0);
    chk("R2 run low", run, 0);
    do_reset();
    chk("R6 wai released", run, 1);
  endtask

  task automatic t_stp_emu();
    int bad;
    pulse_wai_irq(0, 1, 0);
    chk("R5 run low after stp", run, 0);
    pulse_wai_irq(0, 0, 1);
    chk("R5 irq ignored", run, 0);
    wait_cyc(20);
    chk("R7 phi2 held high after stp", phi2, 1);
    emu = 1'b1; sync = 1'b1;
    @(negedge clk);
    chk("R8 emu phi2 high shows run", status, 0);
    emu = 1'b0;
    @(negedge clk);
    chk("R8 normal shows run", status, 0);
    be = 1'b1;
    wait_cyc(3);
    chk("R9 be no effect stopped", run, 0);
    be = 1'b0;
    do_reset();
    chk("R6 stp released", run, 1);
    chk("R6 sc cleared", sc_q, 0);
    emu = 1'b1;
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      sync = i[2];
      #1;
      if (status !== (phi2 ? run : sync)) bad++;
    end
    chk("R8 emu mux mismatches", bad, 0);
    emu = 1'b0;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      be = i[0];
      sync = ~i[1];
      #1;
      if (status !== run || run !== 1'b1) bad++;
    end
    chk("R9 be while running", bad, 0);
    be = 1'b0;
  endtask

  initial begin
    t_reset();
    t_slow();
    t_sel_without_osc();
    t_fast();
    t_wai();
    t_wai_irq_same();
    t_wai_reset();
    t_stp_emu();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule